// File: doc/BRIEF.md
# Triple Interval Timer

The block provides three interval timers on a small 8-bit register bus. Each timer owns a tick strobe input, a period register and a 4-bit event counter. While its enable bit is set, a timer counts its own tick strobes in an internal stage counter. Each time the stage count completes one period, the stage count returns to zero and the event counter goes up by one.

Software reads the event counter to learn how many periods have elapsed since its last read. The read also clears that counter. One shared control byte holds the three enable bits. A period value of zero stands for the longest interval, 256 ticks. Setting an enable bit starts that timer from a clean state.

Top module: `tick_timer_trio`

## Requirements
- R1: After reset every event counter reads 0, every period register holds 0 and every timer is disabled.
- R2: A period register value N in 1..255 gives one event-counter increment per N ticks. The value 0 gives one increment per 256 ticks.
- R3: The event counter is 4 bits wide. It only ever steps by one per increment, and an increment from 15 gives 0.
- R4: A read at address 0xFD+i (i = 0, 1, 2) returns timer i's event counter on rdata_o bits 3:0, with bits 7:4 zero, in the same cycle. The counter is 0 from the next cycle on.
- R5: Bit i of the control register at address 0xF1 enables timer i. While that bit is 0, tick strobes neither advance the stage count nor change the event counter.
- R6: When a timer's enable bit changes from 0 to 1, its stage count and event counter are cleared in the cycle after the control write. A tick presented in that cycle is discarded.
- R7: A write to the period register at 0xFA+i applies from the next tick comparison on. It does not reset the stage count.
- R8: If a read of a counter and a period completion for that counter fall in the same cycle, the read returns the old value and the counter ends at 0. The increment is lost.
- R9: Tick input bit i drives only timer i. Ticks to one timer leave the other timers' counters unchanged.
- R10: rdata_o is 0 whenever no counter address is being read, including reads of 0xF1 and of the period registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Per-timer tick strobes, bit i for timer i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address within the I/O page |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; counter value on a counter read, else 0 |

## Verification
On every cycle, the assertions check four things: the event counter never jumps by more than one, a read always leaves the counter at zero, a disabled timer's state is frozen, and the enable rising edge wipes the timer state. They also check that read data appears only under a read strobe and that period registers change only on writes. Only the bench scenarios can show the arithmetic of the period itself. That covers the 256-tick meaning of zero, the 15-to-0 wrap after seventeen single-tick periods and a retimed period that keeps the partial stage count. The scenarios also show that ticks are discarded in the enable-edge cycle and that the clear wins on a read/increment collision.

// File: rtl/timer_trio_pkg.sv
package timer_trio_pkg;

   // Register map of the I/O page as seen by this block
   localparam int unsigned CTRL_ADDR   = 32'hF1;
   localparam int unsigned PERIOD_BASE = 32'hFA;
   localparam int unsigned COUNT_BASE  = 32'hFD;

   // Default geometry
   localparam int unsigned DEF_NUM_TIMERS = 3;
   localparam int unsigned DEF_ADDR_W     = 8;
   localparam int unsigned DEF_DATA_W     = 8;
   localparam int unsigned DEF_PERIOD_W   = 8;
   localparam int unsigned DEF_EVENT_W    = 4;

endpackage

// File: rtl/timer_trio_regs.sv
module timer_trio_regs #(
   parameter int unsigned NUM_TIMERS  = timer_trio_pkg::DEF_NUM_TIMERS,
   parameter int unsigned ADDR_W      = timer_trio_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W      = timer_trio_pkg::DEF_DATA_W,
   parameter int unsigned PERIOD_W    = timer_trio_pkg::DEF_PERIOD_W,
   parameter int unsigned CTRL_ADDR   = timer_trio_pkg::CTRL_ADDR,
   parameter int unsigned PERIOD_BASE = timer_trio_pkg::PERIOD_BASE,
   parameter int unsigned COUNT_BASE  = timer_trio_pkg::COUNT_BASE
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en_i,
   input  logic                               rd_en_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic [NUM_TIMERS-1:0]              enable_o,
   output logic [NUM_TIMERS-1:0][PERIOD_W-1:0] period_o,
   output logic [NUM_TIMERS-1:0]              rd_clr_o
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic [NUM_TIMERS-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en_i && (addr_i == CTRL_A)) begin
         ctrl_q <= wdata_i[NUM_TIMERS-1:0];
      end
   end

   assign enable_o = ctrl_q;

   for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_dec
      localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(PERIOD_BASE + gi);
      localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(COUNT_BASE + gi);

      logic [PERIOD_W-1:0] period_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            period_q <= '0;
         end else if (wr_en_i && (addr_i == PER_A)) begin
            period_q <= wdata_i[PERIOD_W-1:0];
         end
      end

      assign period_o[gi] = period_q;
      assign rd_clr_o[gi] = rd_en_i && (addr_i == CNT_A);

      // R7
      period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en_i && (addr_i == PER_A)) |=> $stable(period_o[gi]));
   end

   // R4
   one_counter_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_clr_o));

endmodule

// File: rtl/timer_trio_chan.sv
module timer_trio_chan #(
   parameter int unsigned PERIOD_W = timer_trio_pkg::DEF_PERIOD_W,
   parameter int unsigned EVENT_W  = timer_trio_pkg::DEF_EVENT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                tick_i,
   input  logic                rd_clr_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic [EVENT_W-1:0]  count_o
);

   logic                en_prev_q;
   logic [PERIOD_W-1:0] stage_q;
   logic [EVENT_W-1:0]  event_q;
   logic [PERIOD_W-1:0] last_stage;
   logic                en_rise;
   logic                adv;
   logic                done;

   // Period minus one in modulo arithmetic: a zero period becomes the
   // all-ones stage, i.e. 2**PERIOD_W ticks.
   assign last_stage = period_i - 1'b1;
   assign en_rise    = en_i && !en_prev_q;
   assign adv        = en_i && !en_rise && tick_i;
   assign done       = adv && (stage_q == last_stage);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev_q <= 1'b0;
         stage_q   <= '0;
      end else begin
         en_prev_q <= en_i;
         if (en_rise) begin
            stage_q <= '0;
         end else if (done) begin
            stage_q <= '0;
         end else if (adv) begin
            stage_q <= stage_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         event_q <= '0;
      end else if (en_rise || rd_clr_i) begin
         event_q <= '0;
      end else if (done) begin
         event_q <= event_q + 1'b1;
      end
   end

   assign count_o = event_q;

   // R3
   event_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != $past(count_o)) |->
         ((count_o == '0) || (count_o == EVENT_W'($past(count_o) + 1'b1))));

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr_i |=> (count_o == '0));

   // R5
   frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !rd_clr_i) |=> ($stable(count_o) && $stable(stage_q)));

   // R6
   enable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_i) |=> ((count_o == '0) && (stage_q == '0)));

endmodule

// File: rtl/tick_timer_trio.sv
module tick_timer_trio #(
   parameter int unsigned NUM_TIMERS  = timer_trio_pkg::DEF_NUM_TIMERS,
   parameter int unsigned ADDR_W      = timer_trio_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W      = timer_trio_pkg::DEF_DATA_W,
   parameter int unsigned PERIOD_W    = timer_trio_pkg::DEF_PERIOD_W,
   parameter int unsigned EVENT_W     = timer_trio_pkg::DEF_EVENT_W,
   parameter int unsigned CTRL_ADDR   = timer_trio_pkg::CTRL_ADDR,
   parameter int unsigned PERIOD_BASE = timer_trio_pkg::PERIOD_BASE,
   parameter int unsigned COUNT_BASE  = timer_trio_pkg::COUNT_BASE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_TIMERS-1:0] tick_i,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (NUM_TIMERS < 1 || NUM_TIMERS > DATA_W) begin : g_bad_num
      $error("timer count must lie in 1..DATA_W");
   end
   if (EVENT_W < 1 || EVENT_W > DATA_W) begin : g_bad_event
      $error("event counter width must lie in 1..DATA_W");
   end
   if (PERIOD_W < 1 || PERIOD_W > DATA_W) begin : g_bad_period
      $error("period width must lie in 1..DATA_W");
   end
   if (COUNT_BASE + NUM_TIMERS > ADDR_SPAN || PERIOD_BASE + NUM_TIMERS > ADDR_SPAN)
   begin : g_bad_map
      $error("register window exceeds the address space");
   end

   logic [NUM_TIMERS-1:0]               enable;
   logic [NUM_TIMERS-1:0][PERIOD_W-1:0] period;
   logic [NUM_TIMERS-1:0]               rd_clr;
   logic [NUM_TIMERS-1:0][EVENT_W-1:0]  count;

   timer_trio_regs #(
      .NUM_TIMERS  (NUM_TIMERS),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PERIOD_W    (PERIOD_W),
      .CTRL_ADDR   (CTRL_ADDR),
      .PERIOD_BASE (PERIOD_BASE),
      .COUNT_BASE  (COUNT_BASE)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .rd_en_i  (rd_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .enable_o (enable),
      .period_o (period),
      .rd_clr_o (rd_clr)
   );

   for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_chan
      timer_trio_chan #(
         .PERIOD_W (PERIOD_W),
         .EVENT_W  (EVENT_W)
      ) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_i     (enable[gi]),
         .tick_i   (tick_i[gi]),
         .rd_clr_i (rd_clr[gi]),
         .period_i (period[gi]),
         .count_o  (count[gi])
      );
   end

   // Read mux: the decode gives at most one selected counter.
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_TIMERS; i++) begin
         if (rd_clr[i]) begin
            rdata_o = DATA_W'(count[i]);
         end
      end
   end

   // R10
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> (rdata_o == '0));

endmodule

// File: tb/tick_timer_trio_tb_top.sv
`timescale 1ns/1ps
module tick_timer_trio_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tick_i = '0;
   logic       wr_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [7:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;

   int tests_run = 0;
   int tests_failed = 0;
   bit done_flag = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   tick_timer_trio dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o)
   );

   // Monitor: compare read data away from the clock edge
   always @(negedge clk) begin
      if (rst_n && rd_en_i) begin
         tests_run++;
         if (exp_q.size() == 0) begin
            tests_failed++;
            $display("FAIL unexpected read: actual=%0h expected=none", rdata_o);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata_o !== e) begin
               tests_failed++;
               $display("FAIL %s: actual=%0h expected=%0h", t, rdata_o, e);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      step();
      wr_en_i = 1'b0;
   endtask

   task automatic ticks(input logic [2:0] mask, input int n);
      for (int k = 0; k < n; k++) begin
         tick_i = mask;
         step();
      end
      tick_i = '0;
   endtask

   // Driver: push the expected value, then issue the read
   task automatic read_chk(input logic [7:0] a, input logic [7:0] e,
                           input string tag, input logic [2:0] mask);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      rd_en_i = 1'b1; addr_i = a; tick_i = mask;
      step();
      rd_en_i = 1'b0; tick_i = '0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
   endtask

   initial begin
      #(20 * 150000);
      if (!done_flag) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // R1: counters clear after reset
      read_chk(8'hFD, 8'h00, "R1 t0 reset", 3'b000);
      read_chk(8'hFE, 8'h00, "R1 t1 reset", 3'b000);
      read_chk(8'hFF, 8'h00, "R1 t2 reset", 3'b000);
      // R1: disabled after reset, ticks do nothing
      ticks(3'b111, 4);
      read_chk(8'hFF, 8'h00, "R1 disabled after reset", 3'b000);

      write_reg(8'hFA, 8'd3);
      write_reg(8'hFB, 8'd0);
      write_reg(8'hFC, 8'd1);
      write_reg(8'hF1, 8'h07);
      step();

      // R2: period 3, 7 ticks -> 2 (stage left at 1)
      ticks(3'b001, 7);
      read_chk(8'hFD, 8'h02, "R2 period 3", 3'b000);
      // R4: cleared by the read
      read_chk(8'hFD, 8'h00, "R4 read clears", 3'b000);

      // R2: period 0 means 256 ticks
      ticks(3'b010, 255);
      read_chk(8'hFE, 8'h00, "R2 period 0 after 255", 3'b000);
      ticks(3'b010, 1);
      read_chk(8'hFE, 8'h01, "R2 period 0 after 256", 3'b000);

      // R3: period 1, 17 ticks wraps 15 -> 0 then 1
      ticks(3'b100, 17);
      read_chk(8'hFF, 8'h01, "R3 wrap", 3'b000);

      // R9: timer 0 untouched by the other ticks
      read_chk(8'hFD, 8'h00, "R9 independence", 3'b000);

      // R7: stage is 1 of period 3; retime to 5, stage kept
      write_reg(8'hFA, 8'd5);
      ticks(3'b001, 3);
      read_chk(8'hFD, 8'h00, "R7 partial stage", 3'b000);
      ticks(3'b001, 1);
      read_chk(8'hFD, 8'h01, "R7 new period uses old stage", 3'b000);

      // R5: disabled timer ignores ticks
      write_reg(8'hF1, 8'h06);
      step();
      ticks(3'b001, 10);
      read_chk(8'hFD, 8'h00, "R5 disabled", 3'b000);

      // R6: enable edge wipes counter; tick in edge cycle discarded
      ticks(3'b100, 5);
      write_reg(8'hF1, 8'h02);
      step();
      write_reg(8'hF1, 8'h07);
      ticks(3'b100, 1);
      read_chk(8'hFF, 8'h00, "R6 counter wiped", 3'b000);
      ticks(3'b001, 5);
      read_chk(8'hFD, 8'h01, "R6 stage wiped", 3'b000);

      // R8: read/increment collision, clear wins
      ticks(3'b100, 2);
      read_chk(8'hFF, 8'h02, "R8 old value returned", 3'b100);
      read_chk(8'hFF, 8'h00, "R8 increment lost", 3'b000);

      // R10: non-counter reads return 0
      read_chk(8'hF1, 8'h00, "R10 control read", 3'b000);
      read_chk(8'hFA, 8'h00, "R10 period read", 3'b000);

      step();
      step();
      if (exp_q.size() != 0) begin
         tests_run++;
         tests_failed++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end
      done_flag = 1'b1;
      summary();
      $finish;
   end

endmodule